// File: doc/BRIEF.md
# Staggered Multi-Lane PRBS7 Test Generator

This block sits in front of the parallel sample output of a data converter and can replace the live samples with a known pseudo-random test stream. A receiver can use that stream to check the integrity of each data lane and to realign lanes that have slipped against one another. A single 7-stage linear feedback shift register with the polynomial x^7 + x^6 + 1 produces one bit per clock. Twelve output lanes carry that bit stream. Lane 0 carries the newest bit, and each higher lane carries the same stream one clock later than the lane below it. Because of this stagger, the lanes do not all change level on the same edge.

The generator runs without a seed reset, so the pattern can start anywhere in its 127-bit cycle. It keeps running while the test mode is off, so the sequence resumes at its advanced position when the mode is switched back on. If the register ever holds all zeros, the logic forces it back to a nonzero value. A one-bit mode flag selects the output source. Software sets the flag through a simple write port: a strobe, an address and a data byte. Only one bit at one address is decoded. A registered 2:1 selector drives the output word.

Top module: `stagger_prbs_gen`

## Requirements
- R1: While `rst_n` is low, `data_out` is all zeros and test mode is off. After reset is released, the block is in pass-through mode.
- R2: A write with `cfg_wr`=1 and `cfg_addr`=0x02 loads the mode flag from `cfg_wdata` bit 4 (1 = test pattern, 0 = samples). The write is taken at edge E. The first word from the new source appears after edge E+1.
- R3: With test mode off, `data_out` at each edge takes the value that `sample_in` held in the cycle before that edge.
- R4: In test mode, each lane carries a bit stream s that obeys s(n) = s(n-6) xor s(n-7) and repeats every 127 clocks. Within one word this means `data_out[k]` = `data_out[k+6]` xor `data_out[k+7]`. One period holds 64 ones.
- R5: In test mode, lane k carries lane k-1 delayed by one clock: `data_out[k]` after an edge equals `data_out[k-1]` before it. Lane 0 carries the newest bit.
- R6: The generator is never reset and never pauses. After test mode has been off for N clocks, the pattern resumes N bits further on, with no restart.
- R7: The generator never stays in the all-zero state. As a result, no test-mode output word is all zeros.
- R8: A write with `cfg_wr` low, or a write to any address other than 0x02, leaves the mode unchanged.
- R9: The bits of `cfg_wdata` other than bit 4 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset of the mode flag and the output register |
| cfg_wr | input | 1 | Write strobe of the control port |
| cfg_addr | input | 8 | Control port address |
| cfg_wdata | input | 8 | Control port write data; bit 4 is the test-mode flag |
| sample_in | input | 12 | Normal sample word |
| data_out | output | 12 | Registered output word: samples or the staggered test stream |

## Verification
The hardest condition to reach is a known pattern position. The generator has no seed and its state is not visible at the ports, so the bench cannot know where the stream starts. The bench therefore recovers the position from the first test-mode word: the twelve staggered lanes show twelve consecutive stream bits. From that word on, the bench advances its own copy of the stream every clock, including the clocks when test mode is off. This lets it check the exact word after the mode is re-enabled and after reset. The all-zero lock-up state cannot be driven from the ports. It arises only from the register's power-up contents, so a checker property watches it directly.

// File: rtl/stagger_prbs_pkg.sv
package stagger_prbs_pkg;

   // Recovery variant used when the shift register holds all zeros
   typedef enum logic [0:0] {
      LOCKUP_RELOAD = 1'b0,   // load a fixed nonzero seed
      LOCKUP_INJECT = 1'b1    // force a one into the feedback bit
   } lockup_style_e;

   localparam int unsigned DEF_LANES     = 12;
   localparam int unsigned DEF_LFSR_W    = 7;
   localparam int unsigned DEF_TAP_HI    = 7;
   localparam int unsigned DEF_TAP_LO    = 6;
   localparam int unsigned DEF_LANE_STEP = 1;
   localparam int unsigned DEF_ADDR_W    = 8;
   localparam int unsigned DEF_DATA_W    = 8;
   localparam int unsigned DEF_CTRL_ADDR = 2;
   localparam int unsigned DEF_CTRL_BIT  = 4;

   // Number of delay stages needed to stagger all lanes
   function automatic int unsigned chain_depth(input int unsigned lanes,
                                               input int unsigned step);
      return (lanes - 1) * step;
   endfunction

endpackage

// File: rtl/stagger_prbs_ctrl.sv
module stagger_prbs_ctrl #(
   parameter int unsigned ADDR_W    = stagger_prbs_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W    = stagger_prbs_pkg::DEF_DATA_W,
   parameter int unsigned CTRL_ADDR = stagger_prbs_pkg::DEF_CTRL_ADDR,
   parameter int unsigned CTRL_BIT  = stagger_prbs_pkg::DEF_CTRL_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              mode_o
);

   localparam logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(CTRL_ADDR);

   logic hit;
   logic mode_q;
   logic unused_wdata_bits;

   assign hit = wr_i && (addr_i == MATCH_ADDR);

   // only one bit of the written word is decoded
   assign unused_wdata_bits = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (hit) begin
         mode_q <= wdata_i[CTRL_BIT];
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/stagger_prbs_lfsr.sv
module stagger_prbs_lfsr #(
   parameter int unsigned                   W      = stagger_prbs_pkg::DEF_LFSR_W,
   parameter int unsigned                   TAP_HI = stagger_prbs_pkg::DEF_TAP_HI,
   parameter int unsigned                   TAP_LO = stagger_prbs_pkg::DEF_TAP_LO,
   parameter stagger_prbs_pkg::lockup_style_e LOCKUP = stagger_prbs_pkg::LOCKUP_RELOAD,
   parameter logic [W-1:0]                  SEED   = W'(1)
) (
   input  logic         clk,
   output logic [W-1:0] state_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] state_d;
   logic         fb;
   logic         is_zero;

   assign fb      = state_q[TAP_HI-1] ^ state_q[TAP_LO-1];
   assign is_zero = (state_q == '0);

   generate
      if (LOCKUP == stagger_prbs_pkg::LOCKUP_RELOAD) begin : g_reload
         always_comb begin
            if (is_zero) begin
               state_d = SEED;
            end else begin
               state_d = {state_q[W-2:0], fb};
            end
         end
      end else begin : g_inject
         always_comb begin
            state_d = {state_q[W-2:0], fb | is_zero};
         end
      end
   endgenerate

   // free-running: no reset, no enable
   always_ff @(posedge clk) begin
      state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/stagger_prbs_lanes.sv
module stagger_prbs_lanes #(
   parameter int unsigned LANES = stagger_prbs_pkg::DEF_LANES,
   parameter int unsigned STEP  = stagger_prbs_pkg::DEF_LANE_STEP
) (
   input  logic             clk,
   input  logic             bit_i,
   output logic [LANES-1:0] lanes_o
);

   localparam int unsigned DEPTH = stagger_prbs_pkg::chain_depth(LANES, STEP);

   assign lanes_o[0] = bit_i;

   generate
      if (LANES > 1 && STEP == 0) begin : g_flat
         assign lanes_o[LANES-1:1] = {(LANES-1){bit_i}};
      end else if (LANES > 1) begin : g_chain
         logic [DEPTH-1:0] tap_q;
         if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
               tap_q <= bit_i;
            end
         end else begin : g_many
            always_ff @(posedge clk) begin
               tap_q <= {tap_q[DEPTH-2:0], bit_i};
            end
         end
         for (genvar k = 1; k < LANES; k++) begin : g_pick
            assign lanes_o[k] = tap_q[k*STEP-1];
         end
      end
   endgenerate

endmodule

// File: rtl/stagger_prbs_outmux.sv
module stagger_prbs_outmux #(
   parameter int unsigned LANES = stagger_prbs_pkg::DEF_LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_pat_i,
   input  logic [LANES-1:0] sample_i,
   input  logic [LANES-1:0] pattern_i,
   output logic [LANES-1:0] word_o
);

   logic [LANES-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (sel_pat_i) begin
         word_q <= pattern_i;
      end else begin
         word_q <= sample_i;
      end
   end

   assign word_o = word_q;

endmodule

// File: rtl/stagger_prbs_gen.sv
module stagger_prbs_gen #(
   parameter int unsigned                     LANES     = stagger_prbs_pkg::DEF_LANES,
   parameter int unsigned                     LFSR_W    = stagger_prbs_pkg::DEF_LFSR_W,
   parameter int unsigned                     TAP_HI    = stagger_prbs_pkg::DEF_TAP_HI,
   parameter int unsigned                     TAP_LO    = stagger_prbs_pkg::DEF_TAP_LO,
   parameter int unsigned                     LANE_STEP = stagger_prbs_pkg::DEF_LANE_STEP,
   parameter int unsigned                     ADDR_W    = stagger_prbs_pkg::DEF_ADDR_W,
   parameter int unsigned                     DATA_W    = stagger_prbs_pkg::DEF_DATA_W,
   parameter int unsigned                     CTRL_ADDR = stagger_prbs_pkg::DEF_CTRL_ADDR,
   parameter int unsigned                     CTRL_BIT  = stagger_prbs_pkg::DEF_CTRL_BIT,
   parameter stagger_prbs_pkg::lockup_style_e LOCKUP    = stagger_prbs_pkg::LOCKUP_RELOAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [LANES-1:0]  sample_in,
   output logic [LANES-1:0]  data_out
);

   localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

   // elaboration-time parameter checks
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("stagger_prbs_gen: LANES must be at least 1");
      end
      if (TAP_HI != LFSR_W) begin : g_bad_tap_hi
         $error("stagger_prbs_gen: TAP_HI must equal LFSR_W");
      end
      if (TAP_LO == 0 || TAP_LO >= TAP_HI) begin : g_bad_tap_lo
         $error("stagger_prbs_gen: TAP_LO must lie in 1..TAP_HI-1");
      end
      if (CTRL_BIT >= DATA_W) begin : g_bad_bit
         $error("stagger_prbs_gen: CTRL_BIT outside the data word");
      end
      if (ADDR_W < 32 && CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("stagger_prbs_gen: CTRL_ADDR does not fit ADDR_W");
      end
   endgenerate

   logic              pat_mode;
   logic [LFSR_W-1:0] lfsr_state;
   logic [LANES-1:0]  pat_word;

   stagger_prbs_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTRL_ADDR(CTRL_ADDR),
      .CTRL_BIT (CTRL_BIT)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (cfg_wr),
      .addr_i (cfg_addr),
      .wdata_i(cfg_wdata),
      .mode_o (pat_mode)
   );

   stagger_prbs_lfsr #(
      .W     (LFSR_W),
      .TAP_HI(TAP_HI),
      .TAP_LO(TAP_LO),
      .LOCKUP(LOCKUP),
      .SEED  (LFSR_SEED)
   ) u_lfsr (
      .clk    (clk),
      .state_o(lfsr_state)
   );

   stagger_prbs_lanes #(
      .LANES(LANES),
      .STEP (LANE_STEP)
   ) u_lanes (
      .clk    (clk),
      .bit_i  (lfsr_state[LFSR_W-1]),
      .lanes_o(pat_word)
   );

   stagger_prbs_outmux #(
      .LANES(LANES)
   ) u_outmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_pat_i(pat_mode),
      .sample_i (sample_in),
      .pattern_i(pat_word),
      .word_o   (data_out)
   );

endmodule

// File: rtl/stagger_prbs_gen_chk.sv
module stagger_prbs_gen_chk #(
   parameter int unsigned LANES     = 12,
   parameter int unsigned LFSR_W    = 7,
   parameter int unsigned TAP_HI    = 7,
   parameter int unsigned TAP_LO    = 6,
   parameter int unsigned LANE_STEP = 1,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 2,
   parameter int unsigned CTRL_BIT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [LANES-1:0]  sample_in,
   input logic [LANES-1:0]  data_out,
   input logic              pat_mode,
   input logic [LFSR_W-1:0] lfsr_state
);

   logic ctrl_hit;
   assign ctrl_hit = cfg_wr && (cfg_addr == ADDR_W'(CTRL_ADDR));

   // R1: reset holds the output and the mode cleared
   always @(negedge clk) begin
      if (!rst_n) begin
         a_reset_clear_r1: assert (data_out == '0 && !pat_mode)
            else $error("reset did not clear output or mode");
      end
   end

   // R2: a decoded write loads the flag from the selected data bit
   p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> (pat_mode == $past(cfg_wdata[CTRL_BIT])));

   // R8: anything but a decoded write leaves the flag alone
   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_hit |=> $stable(pat_mode));

   // R3: sample pass-through one clock later
   p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pat_mode |=> (data_out == $past(sample_in)));

   // R7: the shift register never stays at all zeros
   p_no_lockup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lfsr_state == '0) |=> (lfsr_state != '0));

   generate
      if (LANE_STEP == 1 && LANES > 1) begin : g_stagger
         // R5: each lane repeats its lower neighbour one clock later
         p_lane_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pat_mode && $past(pat_mode)) |=>
               (data_out[LANES-1:1] == $past(data_out[LANES-2:0])));
      end
      if (LANE_STEP == 1 && LANES > TAP_HI) begin : g_recur
         for (genvar k = 0; k + TAP_HI < LANES; k++) begin : g_bit
            // R4: the polynomial recurrence holds across the lanes
            p_recurrence_r4: assert property (@(posedge clk) disable iff (!rst_n)
               $past(pat_mode) |->
                  (data_out[k] == (data_out[k+TAP_LO] ^ data_out[k+TAP_HI])));
         end
      end
      if (LANE_STEP == 1 && LANES >= LFSR_W) begin : g_nonzero
         // R7: a window of LFSR_W stream bits is never all zeros
         p_pattern_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pat_mode) |-> (data_out != '0));
      end
   endgenerate

endmodule

bind stagger_prbs_gen stagger_prbs_gen_chk #(
   .LANES    (LANES),
   .LFSR_W   (LFSR_W),
   .TAP_HI   (TAP_HI),
   .TAP_LO   (TAP_LO),
   .LANE_STEP(LANE_STEP),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CTRL_ADDR(CTRL_ADDR),
   .CTRL_BIT (CTRL_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .sample_in (sample_in),
   .data_out  (data_out),
   .pat_mode  (pat_mode),
   .lfsr_state(lfsr_state)
);

// File: tb/stagger_prbs_gen_tb.sv
`timescale 1ns/1ps
module stagger_prbs_gen_tb_top;

   localparam int LANES = 12;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_wr;
   logic [7:0]       cfg_addr;
   logic [7:0]       cfg_wdata;
   logic [LANES-1:0] sample_in;
   logic [LANES-1:0] data_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // behavioural model state
   bit               m_mode   = 0;
   bit               acq      = 0;
   bit               prev_pat = 0;
   logic [LANES-1:0] prev_word;
   bit               hist[$];
   bit               lane0_log[$];
   bit               logging  = 0;
   string            tag      = "R1";
   logic [31:0]      lcg      = 32'h1234_5678;

   always #2.5 clk = ~clk;

   stagger_prbs_gen dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .sample_in(sample_in),
      .data_out (data_out)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic next_sample();
      lcg       = lcg * 32'd1103515245 + 32'd12345;
      sample_in = lcg[27:16];
   endtask

   // one clock: wait for the edge, then compare against the model
   task automatic step();
      bit               pmode;
      logic [LANES-1:0] exp;
      @(posedge clk);
      #1;
      pmode = m_mode;
      if (acq) begin
         hist.push_front(hist[5] ^ hist[6]);
         if (hist.size() > 20) void'(hist.pop_back());
      end
      if (!rst_n) begin
         chk(data_out == '0, "R1", data_out, '0);
         m_mode   = 0;
         prev_pat = 0;
      end else if (pmode) begin
         chk(data_out != '0, "R7", data_out, '1);
         for (int k = 0; k + 7 < LANES; k++) begin
            chk(data_out[k] == (data_out[k+6] ^ data_out[k+7]), "R4",
                data_out, {LANES{1'bx}});
         end
         if (prev_pat) begin
            chk(data_out[LANES-1:1] == prev_word[LANES-2:0], "R5",
                data_out, {prev_word[LANES-2:0], data_out[0]});
         end
         if (!acq) begin
            hist.delete();
            for (int k = 0; k < LANES; k++) hist.push_back(data_out[k]);
            acq = 1;
         end else begin
            for (int k = 0; k < LANES; k++) exp[k] = hist[k];
            chk(data_out == exp, tag, data_out, exp);
         end
         if (logging) lane0_log.push_back(data_out[0]);
         prev_pat  = 1;
         prev_word = data_out;
      end else begin
         chk(data_out == sample_in, tag, data_out, sample_in);
         prev_pat = 0;
      end
      if (rst_n && cfg_wr && cfg_addr == 8'h02) m_mode = cfg_wdata[4];
   endtask

   task automatic write_ctrl(input logic [7:0] a, input logic [7:0] d);
      cfg_wr    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      step();
      cfg_wr    = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int ones;
      int bad;
      rst_n     = 1'b0;
      cfg_wr    = 1'b0;
      cfg_addr  = 8'h00;
      cfg_wdata = 8'h00;
      sample_in = 12'h5A5;

      // R1: reset state
      tag = "R1";
      repeat (3) step();
      rst_n = 1'b1;

      // R3: pass-through under varied sample words
      tag = "R3";
      for (int i = 0; i < 16; i++) begin next_sample(); step(); end
      sample_in = '1;    step();
      sample_in = '0;    step();
      for (int i = 0; i < LANES; i++) begin sample_in = LANES'(1) << i; step(); end

      // R8: strobe low, wrong address, wrong high address bit
      tag = "R8";
      cfg_wr = 1'b0; cfg_addr = 8'h02; cfg_wdata = 8'h10;
      next_sample(); step();
      next_sample(); step();
      next_sample(); write_ctrl(8'h03, 8'hFF);
      next_sample(); write_ctrl(8'h82, 8'h10);
      for (int i = 0; i < 3; i++) begin next_sample(); step(); end

      // R9: other data bits set, mode bit clear
      tag = "R9";
      next_sample(); write_ctrl(8'h02, 8'hEF);
      for (int i = 0; i < 4; i++) begin next_sample(); step(); end

      // R2: enable; output still samples after the write edge
      tag = "R2";
      sample_in = '0;
      write_ctrl(8'h02, 8'h10);
      step();
      chk(data_out != '0, "R2", data_out, '1);

      // R4/R5: long pattern run while samples keep changing
      tag = "R5";
      logging = 1;
      for (int i = 0; i < 300; i++) begin next_sample(); step(); end
      logging = 0;

      // R4: 127-clock period and 64 ones per period
      bad = 0;
      for (int i = 0; i + 127 < lane0_log.size(); i++) begin
         if (lane0_log[i] != lane0_log[i+127]) bad++;
      end
      chk(bad == 0, "R4", LANES'(bad), '0);
      ones = 0;
      for (int i = 0; i < 127; i++) ones += int'(lane0_log[i]);
      chk(ones == 64, "R4", LANES'(ones), LANES'(64));
      bad = 0;
      for (int i = 0; i + 63 < 127; i++) begin
         if (lane0_log[i] != lane0_log[i+63]) bad++;
      end
      chk(bad != 0, "R4", LANES'(bad), '1);

      // R9: disable with all other bits set
      tag = "R9";
      next_sample(); write_ctrl(8'h02, 8'h0F);
      tag = "R3";
      for (int i = 0; i < 37; i++) begin next_sample(); step(); end

      // R6: re-enable; pattern resumes at the advanced position
      tag = "R6";
      next_sample(); write_ctrl(8'h02, 8'hFF);
      for (int i = 0; i < 50; i++) begin next_sample(); step(); end

      // R1: reset in mid-run clears the mode
      tag = "R1";
      rst_n = 1'b0;
      repeat (3) begin next_sample(); step(); end
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin next_sample(); step(); end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule